// File: doc/BRIEF.md
# Tag-Matching Reservation Station Pool

This block holds instructions waiting for one class of functional unit, for example the floating-point adder. The issue stage offers one instruction per cycle: an opcode and, for each of its two source operands, either the value itself or the tag of the station that will produce it. A tag of zero marks an operand whose value is already present. An accepted instruction goes into the lowest-numbered free entry. It takes on that entry's fixed tag, and the block shows that tag to the issue stage before acceptance, so the issue stage can rename the destination register.

Every entry watches a result bus that carries a data word and the tag of the station that produced it. A waiting operand whose tag matches the broadcast copies the data and clears its tag. An instruction issued in the same cycle as a matching broadcast gets the value forwarded, so it never misses that result. An entry whose two tags are both zero is ready. Each cycle the oldest ready entry is offered to the execution unit, which always accepts it. That entry stays occupied until its own tag appears on the result bus, and it can then be reused.

Top module: `rs_pool`

## Requirements
- R1: After reset every entry is free: `iss_full` is 0, `ex_valid` is 0 and `iss_tag` equals `TAG_BASE`.
- R2: Entry i carries the fixed tag `TAG_BASE + i`, and none of these tags is zero. While the pool is not full, `iss_tag` shows the tag of the lowest-indexed free entry. An instruction presented with `iss_valid` goes into that entry at the clock edge.
- R3: `iss_full` is 1 exactly when every entry is occupied. An instruction presented while `iss_full` is 1 is dropped and never reaches the execution port.
- R4: An operand tag of 0 means the accompanied value is final. A nonzero tag means the operand waits for the station with that tag.
- R5: When `res_valid` is 1 and `res_tag` equals the nonzero tag of a waiting operand, the operand takes `res_data` at that edge and its tag becomes 0.
- R6: If an issued operand's nonzero tag equals `res_tag` while `res_valid` is 1 in the issue cycle, the entry stores `res_data` as that operand and treats it as present.
- R7: An entry is offered on the execution port only while both of its tags are 0. Each issued instruction is offered in exactly one cycle. The offer appears combinationally in the cycle after the edge at which the entry became ready.
- R8: At most one entry is offered per cycle. Among the ready entries, the one issued earliest is chosen.
- R9: When `res_valid` is 1 and `res_tag` equals an entry's own tag, that entry becomes free at that edge and can accept an instruction from the next cycle on.
- R10: While `ex_valid` is 1, the port shows the chosen entry's tag, opcode and the two operand values, with operand a first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Instruction offered for issue |
| iss_op | input | OP_W | Operation code |
| opa_tag | input | TAG_W | Producer tag of operand a, 0 when the value is present |
| opa_val | input | DATA_W | Value of operand a |
| opb_tag | input | TAG_W | Producer tag of operand b, 0 when the value is present |
| opb_val | input | DATA_W | Value of operand b |
| iss_full | output | 1 | No free entry, so issue stalls |
| iss_tag | output | TAG_W | Tag the next accepted instruction receives |
| res_valid | input | 1 | Result broadcast present |
| res_tag | input | TAG_W | Tag of the station that produced the result |
| res_data | input | DATA_W | Broadcast result value |
| ex_valid | output | 1 | An entry is offered for execution |
| ex_tag | output | TAG_W | Tag of the offered entry |
| ex_op | output | OP_W | Opcode of the offered entry |
| ex_a | output | DATA_W | Operand a of the offered entry |
| ex_b | output | DATA_W | Operand b of the offered entry |

## Verification
The bench goes after several corner cases. The first is a broadcast that lands in the same cycle as the issue of a consumer. Without forwarding, that entry would wait forever on a tag that has already passed. The second is a single broadcast that wakes several entries at once, where a wrong age order would send a younger instruction first. The bench also issues into a full pool: a design that accepted the instruction would overwrite a live entry or later offer an instruction that was never accepted. Finally, it releases an entry and reuses it right away, so that stale age or started state would show up as a repeated or a missing dispatch.

// File: rtl/rsp_pkg.sv
// Shared widths and the per-entry instruction record of the station pool.
package rsp_pkg;
    parameter int DATA_W = 64;
    parameter int TAG_W  = 4;
    parameter int OP_W   = 4;

    // One instruction as held in an entry: opcode, two tag/value operand pairs.
    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [TAG_W-1:0]  ta;
        logic [DATA_W-1:0] va;
        logic [TAG_W-1:0]  tb;
        logic [DATA_W-1:0] vb;
    } rsp_instr_t;
endpackage

// File: rtl/rsp_entry.sv
// One station entry. It stores an instruction, fills waiting operands from
// the result bus by tag match, reports readiness and frees itself when its
// own tag is broadcast. Assumes alloc_i is only raised while the entry is
// free, and that grant_i is only raised while ready_o is high.
module rsp_entry
    import rsp_pkg::*;
#(
    parameter logic [TAG_W-1:0] MY_TAG = 4'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  rsp_instr_t        instr_i,
    input  logic              res_valid_i,
    input  logic [TAG_W-1:0]  res_tag_i,
    input  logic [DATA_W-1:0] res_data_i,
    input  logic              grant_i,
    output logic              busy_o,
    output logic              ready_o,
    output rsp_instr_t        slot_o
);
    logic started;

    // Load, snoop, mark dispatched, and release on own broadcast.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o  <= 1'b0;
            started <= 1'b0;
            slot_o  <= '0;
        end else if (alloc_i) begin
            busy_o  <= 1'b1;
            started <= 1'b0;
            slot_o  <= instr_i;
        end else if (busy_o) begin
            if (res_valid_i && slot_o.ta != '0 && slot_o.ta == res_tag_i) begin
                slot_o.va <= res_data_i;
                slot_o.ta <= '0;
            end
            if (res_valid_i && slot_o.tb != '0 && slot_o.tb == res_tag_i) begin
                slot_o.vb <= res_data_i;
                slot_o.tb <= '0;
            end
            if (grant_i) started <= 1'b1;
            if (res_valid_i && res_tag_i == MY_TAG) busy_o <= 1'b0;
        end
    end

    // Ready: occupied, not yet sent, both operands present.
    always_comb ready_o = busy_o && !started && slot_o.ta == '0 && slot_o.tb == '0;
endmodule

// File: rtl/rsp_age.sv
// Age matrix with oldest-first pick. older[i][j] set means entry i was
// allocated before entry j. Assumes at most one allocation per cycle.
module rsp_age #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] alloc_i,
    input  logic [N-1:0] ready_i,
    output logic [N-1:0] grant_o
);
    logic [N-1:0] older [N];
    logic [N-1:0] cand;

    generate
        for (genvar i = 0; i < N; i++) begin : g_row
            for (genvar j = 0; j < N; j++) begin : g_col
                // Track relative age: a fresh entry is younger than all others.
                always_ff @(posedge clk) begin
                    if (!rst_n)                 older[i][j] <= 1'b0;
                    else if (i == j)            older[i][j] <= 1'b0;
                    else if (alloc_i[i])        older[i][j] <= 1'b0;
                    else if (alloc_i[j])        older[i][j] <= 1'b1;
                end
            end
        end
    endgenerate

    // Candidate: ready and no older ready entry exists.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            cand[i] = ready_i[i];
            for (int j = 0; j < N; j++)
                if (j != i && ready_i[j] && older[j][i]) cand[i] = 1'b0;
        end
    end

    // Lowest-index candidate wins any remaining tie.
    always_comb begin
        grant_o = '0;
        for (int i = N - 1; i >= 0; i--)
            if (cand[i]) grant_o = N'(1) << i;
    end
endmodule

// File: rtl/rs_pool.sv
// Reservation station pool for one functional-unit class. Allocates the
// lowest free entry, forwards a same-cycle broadcast into the new entry,
// and offers the oldest ready entry to an execution unit that always
// accepts. Assumes TAG_BASE > 0 and TAG_BASE + N_ENT - 1 fits in TAG_W.
module rs_pool
    import rsp_pkg::*;
#(
    parameter int               N_ENT    = 3,
    parameter logic [TAG_W-1:0] TAG_BASE = 4'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [TAG_W-1:0]  opa_tag,
    input  logic [DATA_W-1:0] opa_val,
    input  logic [TAG_W-1:0]  opb_tag,
    input  logic [DATA_W-1:0] opb_val,
    output logic              iss_full,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_data,
    output logic              ex_valid,
    output logic [TAG_W-1:0]  ex_tag,
    output logic [OP_W-1:0]   ex_op,
    output logic [DATA_W-1:0] ex_a,
    output logic [DATA_W-1:0] ex_b
);
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    logic [N_ENT-1:0] busy, ready, alloc, grant;
    logic [IDX_W-1:0] free_idx;
    rsp_instr_t       new_instr;
    rsp_instr_t       slots [N_ENT];

    // Lowest free entry and full flag.
    always_comb begin
        free_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--)
            if (!busy[i]) free_idx = IDX_W'(i);
        iss_full = &busy;
        iss_tag  = TAG_BASE + TAG_W'(free_idx);
    end

    // Build the entry image, forwarding a matching broadcast of this cycle.
    always_comb begin
        new_instr    = '{op: iss_op, ta: opa_tag, va: opa_val, tb: opb_tag, vb: opb_val};
        if (res_valid && opa_tag != '0 && opa_tag == res_tag) begin
            new_instr.ta = '0;
            new_instr.va = res_data;
        end
        if (res_valid && opb_tag != '0 && opb_tag == res_tag) begin
            new_instr.tb = '0;
            new_instr.vb = res_data;
        end
    end

    // One-hot allocation strobe.
    always_comb alloc = (iss_valid && !iss_full) ? (N_ENT'(1) << free_idx) : '0;

    generate
        for (genvar g = 0; g < N_ENT; g++) begin : g_ent
            rsp_entry #(.MY_TAG(TAG_BASE + TAG_W'(g))) u_ent (
                .clk         (clk),
                .rst_n       (rst_n),
                .alloc_i     (alloc[g]),
                .instr_i     (new_instr),
                .res_valid_i (res_valid),
                .res_tag_i   (res_tag),
                .res_data_i  (res_data),
                .grant_i     (grant[g]),
                .busy_o      (busy[g]),
                .ready_o     (ready[g]),
                .slot_o      (slots[g])
            );
        end
    endgenerate

    rsp_age #(.N(N_ENT)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .alloc_i (alloc),
        .ready_i (ready),
        .grant_o (grant)
    );

    // Steer the granted entry onto the execution port.
    always_comb begin
        ex_valid = |grant;
        ex_tag   = '0;
        ex_op    = '0;
        ex_a     = '0;
        ex_b     = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (grant[i]) begin
                ex_tag = TAG_BASE + TAG_W'(i);
                ex_op  = slots[i].op;
                ex_a   = slots[i].va;
                ex_b   = slots[i].vb;
            end
        end
    end
endmodule

// File: rtl/rs_pool_chk.sv
// Port-level properties of the station pool, bound into every instance.
module rs_pool_chk
    import rsp_pkg::*;
#(
    parameter int               N_ENT    = 3,
    parameter logic [TAG_W-1:0] TAG_BASE = 4'd1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_full,
    input logic [TAG_W-1:0] iss_tag,
    input logic             res_valid,
    input logic [TAG_W-1:0] res_tag,
    input logic             ex_valid,
    input logic [TAG_W-1:0] ex_tag
);
    localparam logic [TAG_W-1:0] TAG_LAST = TAG_BASE + TAG_W'(N_ENT - 1);
    logic own_res;
    always_comb own_res = res_valid && res_tag >= TAG_BASE && res_tag <= TAG_LAST;

    a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!iss_full && !ex_valid && iss_tag == TAG_BASE));

    a_r2_tag_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_full |-> (iss_tag >= TAG_BASE && iss_tag <= TAG_LAST));

    a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_full && !own_res) |=> iss_full);

    a_r9_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_full && own_res) |=> !iss_full);

    a_r7_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid |=> !(ex_valid && ex_tag == $past(ex_tag)));

    a_r8_ex_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid |-> (ex_tag >= TAG_BASE && ex_tag <= TAG_LAST));
endmodule

bind rs_pool rs_pool_chk #(.N_ENT(N_ENT), .TAG_BASE(TAG_BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_full  (iss_full),
    .iss_tag   (iss_tag),
    .res_valid (res_valid),
    .res_tag   (res_tag),
    .ex_valid  (ex_valid),
    .ex_tag    (ex_tag)
);

// File: tb/rs_pool_test.sv
module rs_pool_test;
    import rsp_pkg::*;
    localparam int N = 3;
    localparam logic [TAG_W-1:0] TB = 4'd1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iss_valid = 0, res_valid = 0;
    logic [OP_W-1:0] iss_op = '0;
    logic [TAG_W-1:0] opa_tag = '0, opb_tag = '0, res_tag = '0;
    logic [DATA_W-1:0] opa_val = '0, opb_val = '0, res_data = '0;
    logic iss_full, ex_valid;
    logic [TAG_W-1:0] iss_tag, ex_tag;
    logic [OP_W-1:0] ex_op;
    logic [DATA_W-1:0] ex_a, ex_b;

    always #5 clk = ~clk;

    rs_pool uut (.*);

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Bench model of the pool.
    bit              m_busy [N], m_start [N];
    logic [OP_W-1:0] m_op [N];
    logic [TAG_W-1:0]  m_ta [N], m_tb [N];
    logic [DATA_W-1:0] m_va [N], m_vb [N];
    int m_stamp [N];
    int stamp_cnt = 0;

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [TAG_W-1:0] tag_of(int k);
        return TB + TAG_W'(k);
    endfunction

    function automatic int exp_pick();
        int best = -1;
        for (int k = 0; k < N; k++)
            if (m_busy[k] && !m_start[k] && m_ta[k] == 0 && m_tb[k] == 0 &&
                (best < 0 || m_stamp[k] < m_stamp[best])) best = k;
        return best;
    endfunction

    function automatic int exp_free();
        for (int k = 0; k < N; k++) if (!m_busy[k]) return k;
        return -1;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < N; k++) begin
            m_busy[k] = 0; m_start[k] = 0;
        end
    endtask

    // Advance the model by one edge using the inputs then applied.
    task automatic model_edge();
        int g, a;
        g = exp_pick();
        a = exp_free();
        for (int k = 0; k < N; k++) begin
            if (m_busy[k]) begin
                if (res_valid && m_ta[k] != 0 && m_ta[k] == res_tag) begin m_va[k] = res_data; m_ta[k] = 0; end
                if (res_valid && m_tb[k] != 0 && m_tb[k] == res_tag) begin m_vb[k] = res_data; m_tb[k] = 0; end
                if (k == g) m_start[k] = 1;
                if (res_valid && res_tag == tag_of(k)) m_busy[k] = 0;
            end
        end
        if (iss_valid && a >= 0) begin
            m_busy[a] = 1; m_start[a] = 0; m_op[a] = iss_op;
            m_ta[a] = opa_tag; m_va[a] = opa_val; m_tb[a] = opb_tag; m_vb[a] = opb_val;
            if (res_valid && opa_tag != 0 && opa_tag == res_tag) begin m_ta[a] = 0; m_va[a] = res_data; end
            if (res_valid && opb_tag != 0 && opb_tag == res_tag) begin m_tb[a] = 0; m_vb[a] = res_data; end
            m_stamp[a] = stamp_cnt++;
        end
    endtask

    task automatic compare();
        int g, a;
        bit ef;
        g = exp_pick();
        a = exp_free();
        ef = (a < 0);
        chk(iss_full == ef, "R3 R9 iss_full", 64'(iss_full), 64'(ef));
        if (!ef) chk(iss_tag == tag_of(a), "R2 iss_tag", 64'(iss_tag), 64'(tag_of(a)));
        chk(ex_valid == (g >= 0), "R4 R7 ex_valid", 64'(ex_valid), 64'(g >= 0));
        if (g >= 0 && ex_valid) begin
            chk(ex_tag == tag_of(g), "R8 oldest ex_tag", 64'(ex_tag), 64'(tag_of(g)));
            chk(ex_op == m_op[g], "R10 ex_op", 64'(ex_op), 64'(m_op[g]));
            chk(ex_a == m_va[g], "R5 R6 ex_a", ex_a, m_va[g]);
            chk(ex_b == m_vb[g], "R5 R6 ex_b", ex_b, m_vb[g]);
        end
    endtask

    // Check at the falling edge, drive, then advance the model at the rising edge.
    task automatic step(bit iv, logic [OP_W-1:0] op, logic [TAG_W-1:0] ta, logic [DATA_W-1:0] va,
                        logic [TAG_W-1:0] tb, logic [DATA_W-1:0] vb,
                        bit rv, logic [TAG_W-1:0] rt, logic [DATA_W-1:0] rd);
        @(negedge clk);
        compare();
        iss_valid = iv; iss_op = op; opa_tag = ta; opa_val = va; opb_tag = tb; opb_val = vb;
        res_valid = rv; res_tag = rt; res_data = rd;
        @(posedge clk);
        model_edge();
    endtask

    function automatic logic [TAG_W-1:0] rand_src();
        int r = $urandom_range(0, 9);
        if (r < 5) return '0;
        if (r < 7) begin
            for (int t = 0; t < 4; t++) begin
                int k = $urandom_range(0, N - 1);
                if (m_busy[k]) return tag_of(k);
            end
        end
        return TAG_W'(4 + $urandom_range(0, 3));
    endfunction

    function automatic logic [TAG_W-1:0] rand_res();
        if ($urandom_range(0, 1) == 1) begin
            for (int t = 0; t < 4; t++) begin
                int k = $urandom_range(0, N - 1);
                if (m_busy[k] && m_start[k]) return tag_of(k);
            end
        end
        return TAG_W'(4 + $urandom_range(0, 3));
    endfunction

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        chk(!iss_full, "R1 iss_full", 64'(iss_full), 64'd0);
        chk(!ex_valid, "R1 ex_valid", 64'(ex_valid), 64'd0);
        chk(iss_tag == TB, "R1 iss_tag", 64'(iss_tag), 64'(TB));
        // Fill: three entries waiting on foreign tag 5.
        step(1, 4'h1, 4'd5, 64'h0, 4'd0, 64'hA1, 0, 0, 0);
        step(1, 4'h2, 4'd5, 64'h0, 4'd0, 64'hA2, 0, 0, 0);
        step(1, 4'h3, 4'd0, 64'hB3, 4'd5, 64'h0, 0, 0, 0);
        // R3: issue while full is dropped.
        step(1, 4'hF, 4'd0, 64'hDEAD, 4'd0, 64'hBEEF, 0, 0, 0);
        // R5 R8: one broadcast wakes all three; age order follows.
        step(0, 0, 0, 0, 0, 0, 1, 4'd5, 64'h5555);
        repeat (4) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R9: release entry 1 then reuse it at once.
        step(0, 0, 0, 0, 0, 0, 1, 4'd2, 64'h22);
        // R6: issue with same-cycle broadcast of its producer tag 6.
        step(1, 4'h7, 4'd6, 64'h0, 4'd6, 64'h0, 1, 4'd6, 64'h6666);
        repeat (2) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
        // Release everything.
        for (int k = 0; k < N; k++) step(0, 0, 0, 0, 0, 0, 1, tag_of(k), 64'(k));
        // Random traffic.
        for (int c = 0; c < 3000; c++) begin
            bit rv = ($urandom_range(0, 1) == 1);
            logic [TAG_W-1:0] rt = rand_res();
            step($urandom_range(0, 9) < 6, OP_W'($urandom), rand_src(), {$urandom, $urandom},
                 rand_src(), {$urandom, $urandom}, rv, rt, {$urandom, $urandom});
        end
        @(negedge clk);
        compare();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule